// File: doc/BRIEF.md
# Prioritized Interrupt State Controller

This block manages a small group of interrupt sources that all target a single CPU. Every source holds one of three lifecycle states (idle, pending, active), plus a programmable priority and a mask bit. A source that fires while idle becomes pending. The block raises `irq` whenever an unmasked pending source has a priority strictly above the priority now being serviced. When nothing is being serviced, any unmasked pending source qualifies.

The CPU claims an interrupt by pulsing `ack`. One cycle later the block returns the chosen source ID on `ack_id`, qualified by `ack_vld`, and moves that source to active. Service can nest. A stack records each activation with the priority the source had at that moment, and the top of the stack is reported as the running interrupt. The CPU finishes an interrupt by pulsing `eoi` with the source ID. Completions must arrive in reverse order of activation.

The acknowledge response has no back-pressure. The CPU must accept the `ack_vld` pulse in the cycle it appears, and it may issue one `ack` per cycle. The configuration port is a plain write strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all sources are idle, unmasked and at priority 0. `irq`, `ack_vld`, `eoi_err` and `run_vld` are all low.
- R2: A `src_fire` bit sampled while its source is idle makes that source pending at the next edge, and `irq` reflects it in the following cycle.
- R3: A masked pending source never causes `irq` and is never selected. It stays pending, and unmasking it makes it eligible again.
- R4: A pending source is eligible only if its priority is numerically greater than `run_prio`. Equal priority does not preempt. With `run_vld` low, every unmasked pending source is eligible.
- R5: Among eligible sources the highest priority wins. Among equal priorities the lowest source ID wins.
- R6: `ack` in cycle N with an eligible source gives `ack_vld`=1 and `ack_id`=winner in cycle N+1. The winner becomes active, and it becomes the running interrupt (`run_id`, `run_prio` = its priority at that edge). `ack_vld` is low in any cycle that does not follow an `ack`.
- R7: `ack` with no eligible source returns `ack_id` = NSRC (8 by default), which is the spurious ID, and changes no state.
- R8: `eoi` with `eoi_id` equal to `run_id` (while `run_vld`) returns that source to idle. The running interrupt then reverts to the previously activated one, or `run_vld` drops.
- R9: `eoi` naming any other source, or arriving with nothing running, pulses `eoi_err` in the next cycle and changes no state.
- R10: A fire on a pending or active source is ignored. It produces no second pending entry after completion.
- R11: A `cfg_we` write with `cfg_idx` < NSRC sets that source's priority and mask at the next edge. Writes with a larger index are ignored. An active source keeps the priority it had when it was activated.
- R12: When `ack` and `eoi` are in the same cycle, the acknowledge is processed and the end-of-interrupt is rejected as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_fire | input | NSRC | Per-source fire pulses |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDW | Source index for the configuration write |
| cfg_prio | input | PW | Priority to write (larger is more urgent) |
| cfg_mask | input | 1 | Mask to write (1 = masked) |
| ack | input | 1 | CPU acknowledge request |
| eoi | input | 1 | CPU end-of-interrupt strobe |
| eoi_id | input | IDW | Source being completed |
| irq | output | 1 | Interrupt request to the CPU |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_id | output | IDW | Acknowledged source, or NSRC when spurious |
| eoi_err | output | 1 | Out-of-order or invalid end-of-interrupt |
| run_vld | output | 1 | An interrupt is in service |
| run_id | output | IDW | Source in service |
| run_prio | output | PW | Priority of the source in service |

## Verification
A corrupted source state becomes visible within one cycle on `irq`, or at the next acknowledge as a wrong or spurious `ack_id`. A stack that was pushed or popped wrongly shows on `run_id`/`run_prio` in the cycle after the edge, and at the next completion as an unexpected `eoi_err`. The bench compares every output against a behavioural model on every cycle, so a divergence is reported at the first cycle it reaches a port.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_PEND = 2'd1,
    SRC_ACT  = 2'd2
  } src_state_e;
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int PW   = 3,
  parameter int IDW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   fire,
  input  logic              cfg_we,
  input  logic [IDW-1:0]    cfg_idx,
  input  logic [PW-1:0]     cfg_prio,
  input  logic              cfg_mask,
  input  logic              grant_en,
  input  logic [IDW-1:0]    grant_id,
  input  logic              done_en,
  input  logic [IDW-1:0]    done_id,
  output logic [NSRC-1:0]   pend,
  output logic [NSRC-1:0]   mask,
  output logic [NSRC*PW-1:0] prio_flat
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [IDW-1:0] MY_ID = IDW'(i);
    src_state_e    st_q;
    logic [PW-1:0] prio_q;
    logic          mask_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q   <= SRC_IDLE;
        prio_q <= '0;
        mask_q <= 1'b0;
      end else begin
        if (done_en && done_id == MY_ID)
          st_q <= SRC_IDLE;
        else if (grant_en && grant_id == MY_ID)
          st_q <= SRC_ACT;
        else if (fire[i] && st_q == SRC_IDLE)
          st_q <= SRC_PEND;
        if (cfg_we && cfg_idx == MY_ID) begin
          prio_q <= cfg_prio;
          mask_q <= cfg_mask;
        end
      end
    end

    assign pend[i]              = (st_q == SRC_PEND);
    assign mask[i]              = mask_q;
    assign prio_flat[i*PW +: PW] = prio_q;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC = 8,
  parameter int PW   = 3,
  parameter int IDW  = 4
) (
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC-1:0]    mask,
  input  logic [NSRC*PW-1:0] prio_flat,
  input  logic               run_vld,
  input  logic [PW-1:0]      run_prio,
  output logic               win_vld,
  output logic [IDW-1:0]     win_id,
  output logic [PW-1:0]      win_prio
);
  logic [PW-1:0] cand;

  always_comb begin
    win_vld  = 1'b0;
    win_id   = '0;
    win_prio = '0;
    cand     = '0;
    for (int i = 0; i < NSRC; i++) begin
      cand = prio_flat[i*PW +: PW];
      if (pend[i] && !mask[i] && (!run_vld || cand > run_prio) &&
          (!win_vld || cand > win_prio)) begin
        win_vld  = 1'b1;
        win_id   = IDW'(i);
        win_prio = cand;
      end
    end
  end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack #(
  parameter int DEPTH = 8,
  parameter int IDW   = 4,
  parameter int PW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [IDW-1:0] push_id,
  input  logic [PW-1:0]  push_prio,
  input  logic           pop,
  output logic           top_vld,
  output logic [IDW-1:0] top_id,
  output logic [PW-1:0]  top_prio
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]  cnt_q;
  logic [IDW-1:0] id_mem [DEPTH];
  logic [PW-1:0]  pr_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (push) cnt_q <= cnt_q + 1'b1;
    else if (pop)  cnt_q <= cnt_q - 1'b1;
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_mem[j] <= '0;
        pr_mem[j] <= '0;
      end else if (push && cnt_q == CW'(j)) begin
        id_mem[j] <= push_id;
        pr_mem[j] <= push_prio;
      end
    end
  end

  always_comb begin
    top_id   = '0;
    top_prio = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (cnt_q == CW'(j + 1)) begin
        top_id   = id_mem[j];
        top_prio = pr_mem[j];
      end
    end
  end

  assign top_vld = (cnt_q != '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int PW   = 3,
  localparam int IDW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_fire,
  input  logic            cfg_we,
  input  logic [IDW-1:0]  cfg_idx,
  input  logic [PW-1:0]   cfg_prio,
  input  logic            cfg_mask,
  input  logic            ack,
  input  logic            eoi,
  input  logic [IDW-1:0]  eoi_id,
  output logic            irq,
  output logic            ack_vld,
  output logic [IDW-1:0]  ack_id,
  output logic            eoi_err,
  output logic            run_vld,
  output logic [IDW-1:0]  run_id,
  output logic [PW-1:0]   run_prio
);
  localparam logic [IDW-1:0] SPUR_ID = IDW'(NSRC);

  logic [NSRC-1:0]    pend, mask;
  logic [NSRC*PW-1:0] prio_flat;
  logic               win_vld;
  logic [IDW-1:0]     win_id;
  logic [PW-1:0]      win_prio;
  logic               grant_en, done_en;

  assign grant_en = ack && win_vld;
  assign done_en  = eoi && !ack && run_vld && (eoi_id == run_id);

  pic_src_bank #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_bank (
    .clk(clk), .rst_n(rst_n), .fire(src_fire),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_mask(cfg_mask),
    .grant_en(grant_en), .grant_id(win_id),
    .done_en(done_en), .done_id(eoi_id),
    .pend(pend), .mask(mask), .prio_flat(prio_flat)
  );

  pic_arbiter #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_arb (
    .pend(pend), .mask(mask), .prio_flat(prio_flat),
    .run_vld(run_vld), .run_prio(run_prio),
    .win_vld(win_vld), .win_id(win_id), .win_prio(win_prio)
  );

  pic_nest_stack #(.DEPTH(NSRC), .IDW(IDW), .PW(PW)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(grant_en), .push_id(win_id), .push_prio(win_prio),
    .pop(done_en),
    .top_vld(run_vld), .top_id(run_id), .top_prio(run_prio)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vld <= 1'b0;
      ack_id  <= '0;
      eoi_err <= 1'b0;
    end else begin
      ack_vld <= ack;
      if (ack) ack_id <= win_vld ? win_id : SPUR_ID;
      eoi_err <= eoi && !done_en;
    end
  end

  assign irq = win_vld;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int PW   = 3,
  localparam int IDW = $clog2(NSRC + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ack,
  input logic           eoi,
  input logic [IDW-1:0] eoi_id,
  input logic           irq,
  input logic           ack_vld,
  input logic [IDW-1:0] ack_id,
  input logic           eoi_err,
  input logic           run_vld,
  input logic [IDW-1:0] run_id,
  input logic [PW-1:0]  run_prio
);
  localparam logic [IDW-1:0] SPUR_ID = IDW'(NSRC);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !ack_vld);

  p_ack_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq |=> ack_vld && run_vld && run_id == ack_id && ack_id != SPUR_ID);

  p_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !irq |=> ack_vld && ack_id == SPUR_ID && $stable(run_vld) && $stable(run_id));

  p_strict_nest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq && run_vld |=> run_prio > $past(run_prio));

  p_eoi_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !ack && run_vld && eoi_id == run_id |=> !eoi_err);

  p_eoi_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !ack && !(run_vld && eoi_id == run_id) |=>
      eoi_err && $stable(run_vld) && $stable(run_id));

  p_ack_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack && eoi |=> eoi_err);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .eoi_id(eoi_id),
  .irq(irq), .ack_vld(ack_vld), .ack_id(ack_id), .eoi_err(eoi_err),
  .run_vld(run_vld), .run_id(run_id), .run_prio(run_prio)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int NSRC  = 8;
  localparam int PW    = 3;
  localparam int IDW   = 4;
  localparam int SPUR  = NSRC;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_fire = '0;
  logic            cfg_we = 1'b0;
  logic [IDW-1:0]  cfg_idx = '0;
  logic [PW-1:0]   cfg_prio = '0;
  logic            cfg_mask = 1'b0;
  logic            ack = 1'b0;
  logic            eoi = 1'b0;
  logic [IDW-1:0]  eoi_id = '0;
  logic            irq, ack_vld, eoi_err, run_vld;
  logic [IDW-1:0]  ack_id, run_id;
  logic [PW-1:0]   run_prio;

  always #(CLK_P/2) clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .src_fire(src_fire),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_mask(cfg_mask),
    .ack(ack), .eoi(eoi), .eoi_id(eoi_id),
    .irq(irq), .ack_vld(ack_vld), .ack_id(ack_id), .eoi_err(eoi_err),
    .run_vld(run_vld), .run_id(run_id), .run_prio(run_prio)
  );

  // reference model: 0 idle, 1 pending, 2 active
  int    m_st [NSRC];
  int    m_pr [NSRC];
  bit    m_mk [NSRC];
  int    s_id [$];
  int    s_pr [$];
  bit    m_ackv;
  int    m_ackid;
  bit    m_err;
  int    n_chk = 0;
  int    n_fail = 0;
  string cur = "R1";

  function automatic int m_win();
    int w;
    int bp;
    w = -1;
    bp = -1;
    for (int i = 0; i < NSRC; i++)
      if (m_st[i] == 1 && !m_mk[i] && (s_id.size() == 0 || m_pr[i] > s_pr[$]) && m_pr[i] > bp) begin
        w = i;
        bp = m_pr[i];
      end
    return w;
  endfunction

  task automatic chk(string tag, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int  w;
    int  st0 [NSRC];
    bit  eok;
    w   = m_win();
    st0 = m_st;
    eok = eoi && !ack && s_id.size() > 0 && int'(eoi_id) == s_id[$];
    @(posedge clk);
    m_ackv = ack;
    if (ack) m_ackid = (w >= 0) ? w : SPUR;
    m_err = eoi && !eok;
    if (eok) begin
      m_st[s_id[$]] = 0;
      void'(s_id.pop_back());
      void'(s_pr.pop_back());
    end
    if (ack && w >= 0) begin
      m_st[w] = 2;
      s_id.push_back(w);
      s_pr.push_back(m_pr[w]);
    end
    for (int i = 0; i < NSRC; i++)
      if (src_fire[i] && st0[i] == 0) m_st[i] = 1;
    if (cfg_we && int'(cfg_idx) < NSRC) begin
      m_pr[cfg_idx] = int'(cfg_prio);
      m_mk[cfg_idx] = cfg_mask;
    end
    @(negedge clk);
    chk(cur, irq == (m_win() >= 0), irq, m_win() >= 0);
    chk(cur, ack_vld == m_ackv, ack_vld, m_ackv);
    if (m_ackv) chk(cur, int'(ack_id) == m_ackid, ack_id, m_ackid);
    chk(cur, eoi_err == m_err, eoi_err, m_err);
    chk(cur, run_vld == (s_id.size() > 0), run_vld, s_id.size() > 0);
    if (s_id.size() > 0) begin
      chk(cur, int'(run_id) == s_id[$], run_id, s_id[$]);
      chk(cur, int'(run_prio) == s_pr[$], run_prio, s_pr[$]);
    end
    src_fire = '0;
    cfg_we = 1'b0;
    ack = 1'b0;
    eoi = 1'b0;
  endtask

  task automatic cfg(int idx, int p, bit m);
    cfg_we = 1'b1; cfg_idx = IDW'(idx); cfg_prio = PW'(p); cfg_mask = m;
    step();
  endtask
  task automatic fire1(int i);
    src_fire[i] = 1'b1;
    step();
  endtask
  task automatic do_ack();
    ack = 1'b1;
    step();
  endtask
  task automatic do_eoi(int id);
    eoi = 1'b1; eoi_id = IDW'(id);
    step();
  endtask

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      m_st[i] = 0; m_pr[i] = 0; m_mk[i] = 0;
    end
    m_ackv = 0; m_ackid = 0; m_err = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", irq == 0, irq, 0);
    chk("R1", ack_vld == 0, ack_vld, 0);
    chk("R1", eoi_err == 0, eoi_err, 0);
    chk("R1", run_vld == 0, run_vld, 0);
    rst_n = 1'b1;

    cur = "R11";
    cfg(0, 1, 0); cfg(1, 5, 0); cfg(2, 6, 0); cfg(3, 2, 0);
    cfg(4, 6, 0); cfg(5, 2, 0); cfg(6, 7, 0); cfg(7, 3, 0);
    cfg(9, 7, 0);                       // out-of-range index ignored
    fire1(0); do_ack();
    chk("R11", run_prio == 1, run_prio, 1);
    do_eoi(0);

    cur = "R2";
    fire1(3);
    chk("R2", irq == 1, irq, 1);
    cur = "R6";
    do_ack();
    chk("R6", ack_vld == 1 && ack_id == 3, ack_id, 3);
    chk("R6", run_id == 3, run_id, 3);

    cur = "R4";
    fire1(5);                           // equal priority: no preemption
    chk("R4", irq == 0, irq, 0);
    fire1(1);
    chk("R4", irq == 1, irq, 1);
    do_ack();
    chk("R4", ack_id == 1 && run_prio == 5, ack_id, 1);

    cur = "R9";
    do_eoi(3);
    chk("R9", eoi_err == 1, eoi_err, 1);
    chk("R9", run_id == 1, run_id, 1);

    cur = "R8";
    do_eoi(1);
    chk("R8", run_id == 3 && eoi_err == 0, run_id, 3);
    do_eoi(3);
    chk("R8", run_vld == 0 && irq == 1, run_vld, 0);
    do_ack();
    chk("R8", ack_id == 5, ack_id, 5);
    do_eoi(5);

    cur = "R5";
    src_fire[4] = 1'b1; src_fire[2] = 1'b1;
    step();
    do_ack();
    chk("R5", ack_id == 2, ack_id, 2);
    cur = "R7";
    do_ack();
    chk("R7", ack_id == SPUR, ack_id, SPUR);
    do_eoi(2);
    do_ack();
    chk("R5", ack_id == 4, ack_id, 4);
    do_eoi(4);

    cur = "R3";
    cfg(7, 3, 1);
    fire1(7);
    chk("R3", irq == 0, irq, 0);
    do_ack();
    chk("R3", ack_id == SPUR, ack_id, SPUR);
    cfg(7, 3, 0);
    chk("R3", irq == 1, irq, 1);
    do_ack();
    do_eoi(7);

    cur = "R10";
    fire1(0); fire1(0);
    do_ack();
    fire1(0);
    do_eoi(0);
    chk("R10", irq == 0, irq, 0);

    cur = "R12";
    fire1(6); do_ack();
    src_fire[3] = 1'b1;
    step();
    ack = 1'b1; eoi = 1'b1; eoi_id = 6;
    step();
    chk("R12", eoi_err == 1 && run_id == 6, eoi_err, 1);
    do_eoi(6);
    do_ack();
    chk("R12", ack_id == 3, ack_id, 3);
    do_eoi(3);

    cur = "R5";
    for (int k = 0; k < 3000; k++) begin
      src_fire = NSRC'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        cfg_we = 1'b1; cfg_idx = IDW'($urandom); cfg_prio = PW'($urandom);
        cfg_mask = ($urandom_range(0, 3) == 0);
      end
      ack = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) begin
        eoi = 1'b1;
        if (s_id.size() > 0 && $urandom_range(0, 3) != 0) eoi_id = IDW'(s_id[$]);
        else eoi_id = IDW'($urandom);
      end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1: watchdog expired, actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule